// File: doc/BRIEF.md
# Flash command engine

This block runs one short serial-flash command at a time, started by software. The whole command is described by a single control word. That word holds an 8-bit opcode, enable bits for the address, write, dummy and read phases, and the byte counts of those phases, each stored as the count minus one. The address comes from its own 32-bit register. Up to eight transmit bytes come from two 32-bit data registers, and up to eight received bytes are returned in two 32-bit result registers. In both cases the bytes are packed little-endian: byte 0 sits in bits 7:0 of the lower word, and byte 4 sits in bits 7:0 of the upper word.

Software loads the address and data registers, then writes the control word with its execute bit set. It polls the busy bit in the control readback until that bit clears, and then reads the result registers. Toward the flash, the engine presents one byte per transfer on a byte-serial shift interface that uses a valid/ready handshake. It holds a chip-select high for the whole command and inserts idle dummy cycles between the write and read phases.

Top module: `flash_cmd_engine`

## Requirements
- R1: A write with `reg_sel_i` = 0 (control) and bit 0 (execute) set, made while idle, starts a command. On the next cycle the busy bit (bit 1 of `ctrl_o`) reads 1. Bit 0 of `ctrl_o` always reads 0. After completion, `ctrl_o` returns the written word with bits 6:0 cleared. The opcode in bits 31:24 is the first byte sent.
- R2: The phases run in a fixed order: opcode, address, write data, dummy, read data. A phase whose enable bit is clear is skipped, and no transfers other than the enabled ones occur.
- R3: When bit 19 is set, the address phase sends n bytes, where bits 17:16 hold n-1. These are the low 8n bits of the address register (`reg_sel_i` = 1), sent most significant byte first.
- R4: When bit 15 is set, the write phase sends n bytes, where bits 14:12 hold n-1. Byte k comes from bits 8k+7:8k of the 64-bit value {upper (`reg_sel_i` = 3), lower (`reg_sel_i` = 2)}.
- R5: Bits 11:7 give the number of dummy cycles. These are cycles with chip-select high and no transfer offered. A value of 0 gives none.
- R6: When bit 23 is set, the read phase makes n transfers with `xfer_rd_o` = 1 and `tx_byte_o` = 0, where bits 22:20 hold n-1. Received byte k lands in bits 8k+7:8k of {`rdata_hi_o`, `rdata_lo_o`}, and bytes above n-1 read 0. The result registers change only on the final read handshake. They keep their value when the read phase is disabled.
- R7: Chip-select stays high from the cycle after the start until the last handshake, and it falls in the same cycle that busy falls.
- R8: While busy, writes to any register are ignored. This covers a second execute, opcode or count changes, the address and the data.
- R9: While `xfer_valid_o` is high and `xfer_ready_i` is low, the offered byte and direction hold, and the phase does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 address, 2 data lower, 3 data upper |
| reg_wdata_i | input | 32 | Register write data |
| ctrl_o | output | 32 | Control readback with busy at bit 1 |
| rdata_lo_o | output | 32 | Received bytes 0 to 3 |
| rdata_hi_o | output | 32 | Received bytes 4 to 7 |
| cs_o | output | 1 | Chip-select, active high |
| xfer_valid_o | output | 1 | A byte transfer is offered |
| xfer_rd_o | output | 1 | Offered transfer belongs to the read phase |
| xfer_ready_i | input | 1 | Shift side accepts the transfer this cycle |
| tx_byte_o | output | 8 | Byte to shift out |
| rx_byte_i | input | 8 | Byte shifted in, sampled on a read handshake |

## Verification
Busy is due one cycle after the clock edge that takes the execute write. The bench checks it at the falling edge that follows that write. Each byte is compared at the falling edge of the cycle in which its handshake happens, against a queue filled before execute, so the comparison follows the handshake itself and no fixed latency is assumed. The result registers, the chip-select release and the busy clear are all due one cycle after the final handshake. For these, the bench polls busy at falling edges, then checks the result words, the dummy-cycle tally and the drained queue in that same cycle.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int OPC_LSB      = 24;
  localparam int RD_EN_BIT    = 23;
  localparam int RD_CNT_LSB   = 20;
  localparam int ADDR_EN_BIT  = 19;
  localparam int ADDR_CNT_LSB = 16;
  localparam int WR_EN_BIT    = 15;
  localparam int WR_CNT_LSB   = 12;
  localparam int DUMMY_LSB    = 7;
  localparam int BUSY_BIT     = 1;
  localparam int EXEC_BIT     = 0;
  localparam int DUMMY_W      = 5;
  localparam int CNT_W        = DUMMY_W;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_WLO  = 2'd2,
    SEL_WHI  = 2'd3
  } sel_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_WR    = 3'd3,
    PH_DUMMY = 3'd4,
    PH_RD    = 3'd5
  } phase_e;

  typedef struct packed {
    logic [7:0]         opcode;
    logic               rd_en;
    logic [2:0]         rd_n1;
    logic               addr_en;
    logic [1:0]         addr_n1;
    logic               wr_en;
    logic [2:0]         wr_n1;
    logic [DUMMY_W-1:0] dummy;
  } cmd_t;
endpackage

// File: rtl/fce_regs.sv
module fce_regs
  import fce_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  sel_e                sel_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic                busy_i,
  output cmd_t                cmd_o,
  output logic [WORD_W-1:0]   addr_o,
  output logic [2*WORD_W-1:0] wdata_o,
  output logic                start_o,
  output logic [WORD_W-1:0]   ctrl_o
);
  localparam logic [WORD_W-1:0] KEEP_MASK = {WORD_W{1'b1}} << DUMMY_LSB;

  logic [WORD_W-1:0] ctrl_q, addr_q, wlo_q, whi_q;
  logic              wr_ok;

  assign wr_ok   = we_i && !busy_i;
  assign start_o = wr_ok && (sel_i == SEL_CTRL) && wdata_i[EXEC_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      addr_q <= '0;
      wlo_q  <= '0;
      whi_q  <= '0;
    end else if (wr_ok) begin
      unique case (sel_i)
        SEL_CTRL: ctrl_q <= wdata_i & KEEP_MASK;
        SEL_ADDR: addr_q <= wdata_i;
        SEL_WLO:  wlo_q  <= wdata_i;
        SEL_WHI:  whi_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    cmd_o.opcode  = ctrl_q[OPC_LSB +: 8];
    cmd_o.rd_en   = ctrl_q[RD_EN_BIT];
    cmd_o.rd_n1   = ctrl_q[RD_CNT_LSB +: 3];
    cmd_o.addr_en = ctrl_q[ADDR_EN_BIT];
    cmd_o.addr_n1 = ctrl_q[ADDR_CNT_LSB +: 2];
    cmd_o.wr_en   = ctrl_q[WR_EN_BIT];
    cmd_o.wr_n1   = ctrl_q[WR_CNT_LSB +: 3];
    cmd_o.dummy   = ctrl_q[DUMMY_LSB +: DUMMY_W];
  end

  always_comb begin
    ctrl_o           = ctrl_q;
    ctrl_o[BUSY_BIT] = busy_i;
  end

  assign addr_o  = addr_q;
  assign wdata_o = {whi_q, wlo_q};
endmodule

// File: rtl/fce_seq.sv
module fce_seq
  import fce_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  cmd_t             cmd_i,
  input  logic             ready_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             valid_o,
  output logic             hs_o,
  output logic             rd_commit_o,
  output logic             busy_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last, advance;

  function automatic phase_e after(input phase_e p, input cmd_t c);
    if (p < PH_ADDR && c.addr_en)            return PH_ADDR;
    else if (p < PH_WR && c.wr_en)           return PH_WR;
    else if (p < PH_DUMMY && c.dummy != '0)  return PH_DUMMY;
    else if (p < PH_RD && c.rd_en)           return PH_RD;
    else                                     return PH_IDLE;
  endfunction

  always_comb begin
    unique case (phase_q)
      PH_OPC:   last = 1'b1;
      PH_ADDR:  last = (cnt_q == CNT_W'(cmd_i.addr_n1));
      PH_WR:    last = (cnt_q == CNT_W'(cmd_i.wr_n1));
      PH_DUMMY: last = (cnt_q == cmd_i.dummy - CNT_W'(1));
      PH_RD:    last = (cnt_q == CNT_W'(cmd_i.rd_n1));
      default:  last = 1'b0;
    endcase
  end

  assign valid_o = (phase_q == PH_OPC) || (phase_q == PH_ADDR) ||
                   (phase_q == PH_WR)  || (phase_q == PH_RD);
  assign hs_o    = valid_o && ready_i;
  assign advance = (phase_q == PH_DUMMY) || hs_o;
  assign rd_commit_o = hs_o && (phase_q == PH_RD) && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_q <= PH_OPC;
        cnt_q   <= '0;
      end
    end else if (advance) begin
      if (last) begin
        phase_q <= after(phase_q, cmd_i);
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign busy_o  = (phase_q != PH_IDLE);
endmodule

// File: rtl/fce_txsel.sv
module fce_txsel
  import fce_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  phase_e              phase_i,
  input  logic [2:0]          idx_i,
  input  cmd_t                cmd_i,
  input  logic [WORD_W-1:0]   addr_i,
  input  logic [2*WORD_W-1:0] wdata_i,
  output logic [7:0]          tx_byte_o
);
  logic [1:0] aidx;

  // address goes out most significant used byte first
  assign aidx = cmd_i.addr_n1 - idx_i[1:0];

  always_comb begin
    unique case (phase_i)
      PH_OPC:  tx_byte_o = cmd_i.opcode;
      PH_ADDR: tx_byte_o = addr_i[{aidx, 3'b000} +: 8];
      PH_WR:   tx_byte_o = wdata_i[{idx_i, 3'b000} +: 8];
      default: tx_byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/fce_rxpack.sv
module fce_rxpack
  import fce_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                cap_i,
  input  logic                commit_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [7:0]          rx_byte_i,
  output logic [2*WORD_W-1:0] rdata_o
);
  localparam int DATA_BYTES = 2 * WORD_W / 8;

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    logic [7:0] shadow_q, res_q;
    logic       hit;

    assign hit = (cnt_i == CNT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        res_q    <= '0;
      end else begin
        if (clear_i)          shadow_q <= '0;
        else if (cap_i && hit) shadow_q <= rx_byte_i;
        // final byte bypasses the shadow so the result lands on its handshake
        if (commit_i) res_q <= hit ? rx_byte_i : shadow_q;
      end
    end

    assign rdata_o[g*8 +: 8] = res_q;
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] rdata_lo_o,
  output logic [WORD_W-1:0] rdata_hi_o,
  output logic              cs_o,
  output logic              xfer_valid_o,
  output logic              xfer_rd_o,
  input  logic              xfer_ready_i,
  output logic [7:0]        tx_byte_o,
  input  logic [7:0]        rx_byte_i
);
  cmd_t                cmd;
  logic [WORD_W-1:0]   addr;
  logic [2*WORD_W-1:0] wdata, rdata;
  logic                start, busy, valid, hs, commit;
  phase_e              phase;
  logic [CNT_W-1:0]    cnt;

  fce_regs #(.WORD_W(WORD_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (sel_e'(reg_sel_i)),
    .wdata_i (reg_wdata_i),
    .busy_i  (busy),
    .cmd_o   (cmd),
    .addr_o  (addr),
    .wdata_o (wdata),
    .start_o (start),
    .ctrl_o  (ctrl_o)
  );

  fce_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cmd_i       (cmd),
    .ready_i     (xfer_ready_i),
    .phase_o     (phase),
    .cnt_o       (cnt),
    .valid_o     (valid),
    .hs_o        (hs),
    .rd_commit_o (commit),
    .busy_o      (busy)
  );

  fce_txsel #(.WORD_W(WORD_W)) u_txsel (
    .phase_i   (phase),
    .idx_i     (cnt[2:0]),
    .cmd_i     (cmd),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .tx_byte_o (tx_byte_o)
  );

  fce_rxpack #(.WORD_W(WORD_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start),
    .cap_i     (hs && (phase == PH_RD)),
    .commit_i  (commit),
    .cnt_i     (cnt),
    .rx_byte_i (rx_byte_i),
    .rdata_o   (rdata)
  );

  assign cs_o         = busy;
  assign xfer_valid_o = valid;
  assign xfer_rd_o    = (phase == PH_RD);
  assign rdata_lo_o   = rdata[WORD_W-1:0];
  assign rdata_hi_o   = rdata[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/fce_chk.sv
module fce_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic [WORD_W-1:0] reg_wdata_i,
  input logic [WORD_W-1:0] ctrl_o,
  input logic [WORD_W-1:0] rdata_lo_o,
  input logic [WORD_W-1:0] rdata_hi_o,
  input logic              cs_o,
  input logic              xfer_valid_o,
  input logic              xfer_rd_o,
  input logic              xfer_ready_i,
  input logic [7:0]        tx_byte_o
);
  p_busy_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 2'd0 && reg_wdata_i[0] && !ctrl_o[1]) |=> ctrl_o[1]);

  p_exec_reads_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[0]);

  p_xfer_in_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> cs_o);

  p_rd_tx_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && xfer_rd_o) |-> (tx_byte_o == 8'h00));

  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_valid_o && xfer_ready_i && xfer_rd_o) |=>
      ($stable(rdata_lo_o) && $stable(rdata_hi_o)));

  p_cs_busy_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> $fell(ctrl_o[1]));

  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[1] && reg_we_i && reg_sel_i == 2'd0) |=> $stable(ctrl_o[WORD_W-1:2]));

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && !xfer_ready_i) |=>
      (xfer_valid_o && $stable(tx_byte_o) && $stable(xfer_rd_o)));
endmodule

bind flash_cmd_engine fce_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_sel_i    (reg_sel_i),
  .reg_wdata_i  (reg_wdata_i),
  .ctrl_o       (ctrl_o),
  .rdata_lo_o   (rdata_lo_o),
  .rdata_hi_o   (rdata_hi_o),
  .cs_o         (cs_o),
  .xfer_valid_o (xfer_valid_o),
  .xfer_rd_o    (xfer_rd_o),
  .xfer_ready_i (xfer_ready_i),
  .tx_byte_o    (tx_byte_o)
);

// File: tb/sim_flash_cmd_engine.sv
`timescale 1ns/1ps
module sim_flash_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_o, rdata_lo, rdata_hi;
  logic        cs, xvalid, xrd, xready;
  logic [7:0]  tx_byte, rx_byte;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [8:0]  exp_q[$];
  logic [7:0]  rx_seed = 8'h00;
  logic [3:0]  rx_idx;
  bit          stall_mode = 0;
  logic [7:0]  tick;
  int          dummy_seen = 0, exp_dummy = 0, cs_mism = 0;
  logic [31:0] cur_addr = '0, last_ctrl = '0;
  logic [63:0] cur_wd = '0, exp_r = '0;
  bit          prev_stall = 0;
  logic [8:0]  prev_item;

  always #2 clk = ~clk;

  flash_cmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .ctrl_o(ctrl_o), .rdata_lo_o(rdata_lo),
    .rdata_hi_o(rdata_hi), .cs_o(cs), .xfer_valid_o(xvalid), .xfer_rd_o(xrd),
    .xfer_ready_i(xready), .tx_byte_o(tx_byte), .rx_byte_i(rx_byte)
  );

  assign rx_byte = rx_seed + 8'(rx_idx * 8'h11);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0; xready <= 1'b1; rx_idx <= '0;
    end else begin
      tick   <= tick + 8'd1;
      xready <= !stall_mode || (tick[1:0] == 2'd0);
      if (!cs) rx_idx <= '0;
      else if (xvalid && xready && xrd) rx_idx <= rx_idx + 4'd1;
    end
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // monitor: scoreboard pop on every handshake
  always @(negedge clk) if (rst_n && !done) begin
    if (cs !== ctrl_o[1]) cs_mism++;
    if (cs && !xvalid) dummy_seen++;
    if (prev_stall) chk("R9 stalled byte held", {54'd0, xvalid, xrd, tx_byte}, {54'd0, 1'b1, prev_item});
    prev_stall = xvalid && !xready;
    prev_item  = {xrd, tx_byte};
    if (xvalid && xready) begin
      if (exp_q.size() == 0) chk("R2 unexpected transfer", {55'd0, xrd, tx_byte}, 64'h1FF);
      else chk("R2 transfer order/content", {55'd0, xrd, tx_byte}, {55'd0, exp_q.pop_front()});
    end
  end

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [7:0] opc, input bit r_en, input int r_n,
      input bit a_en, input int a_n, input bit w_en, input int w_n, input int dm);
    logic [31:0] w;
    w = '0;
    w[31:24] = opc;
    w[23] = r_en; w[22:20] = 3'(r_n - 1);
    w[19] = a_en; w[17:16] = 2'(a_n - 1);
    w[15] = w_en; w[14:12] = 3'(w_n - 1);
    w[11:7] = 5'(dm);
    return w;
  endfunction

  task automatic issue(input logic [7:0] opc, input bit a_en, input int a_n, input logic [31:0] a,
      input bit w_en, input int w_n, input logic [63:0] wd, input int dm,
      input bit r_en, input int r_n, input logic [7:0] seed, input bit load);
    if (load) begin
      wr_reg(2'd1, a); wr_reg(2'd2, wd[31:0]); wr_reg(2'd3, wd[63:32]);
      cur_addr = a; cur_wd = wd;
    end
    exp_q.push_back({1'b0, opc});
    if (a_en) for (int i = a_n - 1; i >= 0; i--) exp_q.push_back({1'b0, cur_addr[i*8 +: 8]});
    if (w_en) for (int i = 0; i < w_n; i++) exp_q.push_back({1'b0, cur_wd[i*8 +: 8]});
    if (r_en) begin
      for (int i = 0; i < r_n; i++) exp_q.push_back(9'h100);
      exp_r = '0;
      for (int i = 0; i < r_n; i++) exp_r[i*8 +: 8] = seed + 8'(i * 17);
    end
    rx_seed = seed; dummy_seen = 0; exp_dummy = dm; cs_mism = 0;
    last_ctrl = mk_ctrl(opc, r_en, r_n, a_en, a_n, w_en, w_n, dm);
    wr_reg(2'd0, last_ctrl | 32'h1);
    chk("R1 busy after execute", {63'd0, ctrl_o[1]}, 64'd1);
    chk("R1 execute reads zero", {63'd0, ctrl_o[0]}, 64'd0);
  endtask

  task automatic finish_cmd(input string tag);
    for (int i = 0; i < 4000; i++) begin
      if (!ctrl_o[1]) break;
      @(negedge clk);
    end
    chk({"R2 queue drained ", tag}, 64'(exp_q.size()), 64'd0);
    chk({"R5 dummy cycles ", tag}, 64'(dummy_seen), 64'(exp_dummy));
    chk({"R7 cs released ", tag}, {63'd0, cs}, 64'd0);
    chk({"R7 cs tracks busy ", tag}, 64'(cs_mism), 64'd0);
    chk({"R6 read result ", tag}, {rdata_hi, rdata_lo}, exp_r);
    chk({"R1 ctrl readback ", tag}, {32'd0, ctrl_o}, {32'd0, last_ctrl[31:7], 7'd0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ctrl", {32'd0, ctrl_o}, 64'd0);
    chk("R7 reset cs", {62'd0, cs, xvalid}, 64'd0);
    chk("R6 reset rdata", {rdata_hi, rdata_lo}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2: opcode only
    issue(8'h06, 0, 1, 32'h0, 0, 1, 64'h0, 0, 0, 1, 8'h00, 1);
    finish_cmd("opc only");

    // R6: 3-byte read, upper bytes zero
    issue(8'h9F, 0, 1, 32'h0, 0, 1, 64'h0, 0, 1, 3, 8'h40, 0);
    finish_cmd("read3");

    // R3 R4: 3-byte address, 8 write bytes, result unchanged (R6)
    issue(8'h02, 1, 3, 32'h12345678, 1, 8, 64'h8877665544332211, 0, 0, 1, 8'h00, 1);
    finish_cmd("addr3 write8");

    // R3 R5 R6 R9: 4-byte address, 8 dummy, 8 read bytes under backpressure
    stall_mode = 1;
    issue(8'h0B, 1, 4, 32'hA1B2C3D4, 0, 1, 64'h0, 8, 1, 8, 8'h10, 1);
    finish_cmd("fast read stalled");
    stall_mode = 0;

    // R6: 5-byte read after address, partial upper word
    issue(8'h4B, 1, 2, 32'h0000BEEF, 0, 1, 64'h0, 0, 1, 5, 8'hE0, 1);
    finish_cmd("read5");

    // R5: maximum dummy only
    issue(8'hAB, 0, 1, 32'h0, 0, 1, 64'h0, 31, 0, 1, 8'h00, 0);
    finish_cmd("dummy31");

    // R4: single write byte, 1-byte address, write then read
    issue(8'h35, 1, 1, 32'h000000C7, 1, 1, 64'h00000000000000A5, 3, 1, 2, 8'h77, 1);
    finish_cmd("all phases");

    // R8: writes while busy are ignored
    issue(8'h5A, 1, 3, 32'h00ABCDEF, 0, 1, 64'h0, 20, 0, 1, 8'h00, 1);
    wr_reg(2'd0, mk_ctrl(8'hC3, 1, 8, 1, 4, 1, 8, 2) | 32'h1);
    wr_reg(2'd1, 32'hDEADBEEF);
    wr_reg(2'd2, 32'h01020304);
    chk("R8 ctrl unchanged while busy", {32'd0, ctrl_o}, {32'd0, last_ctrl[31:7], 5'd0, 2'b10});
    finish_cmd("busy writes");
    // reuse registers: address and data must be the pre-busy values
    issue(8'h03, 1, 3, 32'h0, 1, 2, 64'h0, 0, 0, 1, 8'h00, 0);
    finish_cmd("R8 old addr/data");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R7 busy never cleared got 1 exp 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule